// File: doc/BRIEF.md
# Pixel Word Serializer

The block turns one parallel pixel per pixel-clock period into a stream of serial bits. Each pixel carries 24 color bits and three timing bits: vertical sync, horizontal sync and data enable. The block adds an odd parity bit and two zero filler bits to make a 30-bit word. It then sends the word over one, two or three data lanes. The fast bit clock is modelled as a clock enable (`bit_en`) on the system clock. One word takes 30, 15 or 10 enables, depending on how many lanes are in use. A forwarded clock marker goes out beside the lanes. It is rebuilt from the bit-enable count, not taken from the pixel clock itself.

The pixel clock enters as a level that is sampled on `clk`. A select input picks which of its edges captures the pixel bus. A second select reverses the bit order of the 24 color bits, so that a host with mirrored wiring can drive the bus directly. If the pixel clock stops toggling, the block drops into standby and its outputs go quiet. It returns to active only after it has seen pixel edges again. A power-enable input forces a shutdown state.

Top module: `pixel_lane_serializer`

## Requirements
- R1: Input bus: `pix_in[26]` is vertical sync, `[25]` is horizontal sync, `[24]` is data enable, `[23:16]` is red, `[15:8]` is green and `[7:0]` is blue. With swap off, word bits `[23:0]` equal `pix_in[23:0]` and bits `[26:24]` equal `pix_in[26:24]`. Bit 27 is parity, bits `[29:28]` are zero, and word bit 0 leaves first.
- R2: The parity bit makes the 27 data bits plus the parity bit contain an odd number of ones.
- R3: With `bus_swap` high, word bit i equals `pix_in[23-i]` for i in 0..23. The three timing bits are not affected.
- R4: `lane_sel` 2 selects two lanes, 3 selects three lanes, and 0 or 1 selects one lane. With N lanes, lane k in slot s carries word bit s*N+k, and a word lasts 30/N bit enables. Lanes at index N and above stay low. The lane count is taken when the word is loaded.
- R5: With `cap_fall` low the rising pixel-clock edge captures the bus; with it high the falling edge does. The captured value is the bus present together with the new clock level. Slot 0 appears on the lanes two `clk` cycles after that level is applied.
- R6: `fclk_out` is high for the first floor(P/2) slots of a P-slot word. It is low for the remaining slots and after the word ends.
- R7: `link_mode` reads 2 for active, 1 for standby and 0 for shutdown. After 64 consecutive bit enables with no pixel-clock edge of either polarity, active drops to standby. Outside active, all lanes and `fclk_out` are low.
- R8: In standby the second capture edge makes the block active. The first word sent is the one taken at the third capture edge.
- R9: `pwr_on` low gives shutdown on the next cycle, and pixel edges are ignored while it stays low. `pwr_on` high again gives standby on the next cycle, after which R8 applies.
- R10: After reset the block is in standby with all lanes and `fclk_out` low.
- R11: While `bit_en` is low, the lanes, `fclk_out` and the idle count do not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Line-rate bit enable |
| pwr_on | input | 1 | Low forces shutdown |
| pclk_in | input | 1 | Pixel clock level, sampled on clk |
| pix_in | input | 27 | Color and timing bits of one pixel |
| cap_fall | input | 1 | Capture on falling pixel edge when high |
| bus_swap | input | 1 | Reverse the 24 color bits |
| lane_sel | input | 2 | Number of active lanes |
| lane_out | output | 3 | Serial data lanes |
| fclk_out | output | 1 | Forwarded word-rate clock marker |
| link_mode | output | 2 | Operating mode |

## Verification
The hardest case to reach is the exact standby boundary. Only an unbroken run of enabled bit-clock cycles without any pixel edge ends active mode, and a correct design never shows it on the lanes until it happens. The stimulus stops the pixel clock right after a falling edge and holds `bit_en` low for about a hundred cycles. This shows that nothing advances: the lanes stay frozen and the mode stays active. It then restores the enables and checks the mode on the 63rd and 64th enabled cycles. Wake-up is driven in the same deliberate way: two pixels go in while no word is expected, so that a word loaded one edge too early shows up as a misaligned stream.

// File: rtl/pxser_pkg.sv
package pxser_pkg;
  localparam int DATA_W    = 27;
  localparam int RGB_W     = 24;
  localparam int WORD_W    = 30;
  localparam int MAX_LANES = 3;
  localparam int SLOT_W    = $clog2(WORD_W + 2);

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_STBY = 2'd1,
    MODE_RUN  = 2'd2
  } link_mode_e;

  function automatic logic [1:0] lanes_used(input logic [1:0] sel);
    return (sel == 2'd0) ? 2'd1 : sel;
  endfunction

  function automatic logic [SLOT_W-1:0] slots_per_word(input logic [1:0] n);
    case (n)
      2'd2:    return SLOT_W'(WORD_W / 2);
      2'd3:    return SLOT_W'(WORD_W / 3);
      default: return SLOT_W'(WORD_W);
    endcase
  endfunction
endpackage

// File: rtl/pxser_framer.sv
module pxser_framer
  import pxser_pkg::*;
(
  input  logic [DATA_W-1:0] pix_i,
  input  logic              swap_i,
  output logic [WORD_W-1:0] word_o
);
  logic [RGB_W-1:0]  rev;
  logic [RGB_W-1:0]  rgb;
  logic [DATA_W-1:0] payload;

  // Mirroring the whole color slice reverses each color field and swaps red with blue
  for (genvar i = 0; i < RGB_W; i++) begin : g_rev
    assign rev[i] = pix_i[RGB_W-1-i];
  end

  assign rgb     = swap_i ? rev : pix_i[RGB_W-1:0];
  assign payload = {pix_i[DATA_W-1:RGB_W], rgb};
  assign word_o  = {{(WORD_W-DATA_W-1){1'b0}}, ~(^payload), payload};
endmodule

// File: rtl/pxser_pclk_mon.sv
module pxser_pclk_mon
  import pxser_pkg::*;
#(
  parameter int STOP_LIM   = 64,
  parameter int WAKE_EDGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic              pwr_on_i,
  input  logic              pclk_i,
  input  logic              cap_fall_i,
  input  logic [DATA_W-1:0] pix_i,
  output logic              cap_o,
  output logic [DATA_W-1:0] pix_o,
  output link_mode_e        mode_o
);
  localparam int IDLE_W = $clog2(STOP_LIM);
  localparam int WK_W   = $clog2(WAKE_EDGES + 1);

  logic              pclk_q, pclk_qq;
  logic [DATA_W-1:0] pix_q;
  link_mode_e        mode_q, mode_d;
  logic [IDLE_W-1:0] idle_q, idle_d;
  logic [WK_W-1:0]   wk_q, wk_d;
  logic              rise, fall, any_edge, idle_hit;

  assign rise     = pclk_q & ~pclk_qq;
  assign fall     = ~pclk_q & pclk_qq;
  assign any_edge = rise | fall;
  assign cap_o    = cap_fall_i ? fall : rise;
  assign idle_hit = (mode_q == MODE_RUN) && !any_edge && bit_en_i &&
                    (idle_q == IDLE_W'(STOP_LIM - 1));

  always_comb begin
    mode_d = mode_q;
    wk_d   = wk_q;
    idle_d = idle_q;
    if ((mode_q != MODE_RUN) || any_edge) begin
      idle_d = '0;
    end else if (bit_en_i && !idle_hit) begin
      idle_d = idle_q + IDLE_W'(1);
    end
    if (!pwr_on_i) begin
      mode_d = MODE_OFF;
      wk_d   = '0;
    end else begin
      case (mode_q)
        MODE_OFF: begin
          mode_d = MODE_STBY;
          wk_d   = '0;
        end
        MODE_STBY: begin
          if (cap_o) begin
            if (wk_q == WK_W'(WAKE_EDGES - 1)) begin
              mode_d = MODE_RUN;
              wk_d   = '0;
            end else begin
              wk_d = wk_q + WK_W'(1);
            end
          end
        end
        MODE_RUN: begin
          if (idle_hit) mode_d = MODE_STBY;
        end
        default: mode_d = MODE_STBY;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pclk_q  <= 1'b0;
      pclk_qq <= 1'b0;
      pix_q   <= '0;
      mode_q  <= MODE_STBY;
      idle_q  <= '0;
      wk_q    <= '0;
    end else begin
      pclk_q  <= pclk_i;
      pclk_qq <= pclk_q;
      pix_q   <= pix_i;
      mode_q  <= mode_d;
      idle_q  <= idle_d;
      wk_q    <= wk_d;
    end
  end

  assign pix_o  = pix_q;
  assign mode_o = mode_q;
endmodule

// File: rtl/pxser_shifter.sv
module pxser_shifter
  import pxser_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bit_en_i,
  input  logic                 run_i,
  input  logic                 load_i,
  input  logic [WORD_W-1:0]    word_i,
  input  logic [1:0]           lane_sel_i,
  output logic [MAX_LANES-1:0] lane_o,
  output logic                 fwd_o
);
  logic [WORD_W-1:0] sr_q, sr_d;
  logic [SLOT_W-1:0] cnt_q, cnt_d;
  logic [SLOT_W-1:0] per;
  logic [1:0]        nl_q, nl_d;
  logic              in_word;

  assign per     = slots_per_word(nl_q);
  assign in_word = run_i && (cnt_q < per);

  always_comb begin
    sr_d  = sr_q;
    cnt_d = cnt_q;
    nl_d  = nl_q;
    if (!run_i) begin
      cnt_d = '1;
    end else if (load_i) begin
      sr_d  = word_i;
      cnt_d = '0;
      nl_d  = lanes_used(lane_sel_i);
    end else if (bit_en_i && (cnt_q < per)) begin
      sr_d  = sr_q >> nl_q;
      cnt_d = cnt_q + SLOT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      cnt_q <= '1;
      nl_q  <= 2'd1;
    end else begin
      sr_q  <= sr_d;
      cnt_q <= cnt_d;
      nl_q  <= nl_d;
    end
  end

  for (genvar k = 0; k < MAX_LANES; k++) begin : g_lane
    assign lane_o[k] = in_word && (nl_q > 2'(k)) && sr_q[k];
  end

  assign fwd_o = run_i && (cnt_q < (per >> 1));
endmodule

// File: rtl/pixel_lane_serializer.sv
module pixel_lane_serializer
  import pxser_pkg::*;
#(
  parameter int STOP_LIM   = 64,
  parameter int WAKE_EDGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bit_en,
  input  logic                 pwr_on,
  input  logic                 pclk_in,
  input  logic [DATA_W-1:0]    pix_in,
  input  logic                 cap_fall,
  input  logic                 bus_swap,
  input  logic [1:0]           lane_sel,
  output logic [MAX_LANES-1:0] lane_out,
  output logic                 fclk_out,
  output logic [1:0]           link_mode
);
  logic              rst_meta, rst_sync;
  logic              cap_stb, load_stb;
  logic [DATA_W-1:0] pix_cap;
  logic [WORD_W-1:0] word;
  link_mode_e        mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  pxser_pclk_mon #(
    .STOP_LIM  (STOP_LIM),
    .WAKE_EDGES(WAKE_EDGES)
  ) u_mon (
    .clk_i     (clk),
    .rst_ni    (rst_sync),
    .bit_en_i  (bit_en),
    .pwr_on_i  (pwr_on),
    .pclk_i    (pclk_in),
    .cap_fall_i(cap_fall),
    .pix_i     (pix_in),
    .cap_o     (cap_stb),
    .pix_o     (pix_cap),
    .mode_o    (mode)
  );

  pxser_framer u_frame (
    .pix_i (pix_cap),
    .swap_i(bus_swap),
    .word_o(word)
  );

  assign load_stb = cap_stb && (mode == MODE_RUN);

  pxser_shifter u_shift (
    .clk_i     (clk),
    .rst_ni    (rst_sync),
    .bit_en_i  (bit_en),
    .run_i     (mode == MODE_RUN),
    .load_i    (load_stb),
    .word_i    (word),
    .lane_sel_i(lane_sel),
    .lane_o    (lane_out),
    .fwd_o     (fclk_out)
  );

  assign link_mode = mode;
endmodule

// File: rtl/pixel_lane_serializer_chk.sv
module pixel_lane_serializer_chk
  import pxser_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bit_en,
  input logic                 pwr_on,
  input logic                 cap,
  input logic                 load,
  input logic [MAX_LANES-1:0] lane_out,
  input logic                 fclk_out,
  input logic [1:0]           link_mode
);
  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (link_mode != MODE_RUN) |-> (lane_out == '0) && !fclk_out); // R7
  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    link_mode != 2'd3); // R10
  AST_PWR_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_on |=> (link_mode == MODE_OFF)); // R9
  AST_OFF_NOT_DIRECT_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (link_mode == MODE_OFF) |=> (link_mode != MODE_RUN)); // R9
  AST_WAKE_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    ((link_mode == MODE_STBY) && !cap) |=> (link_mode != MODE_RUN)); // R8
  AST_LOAD_RAISES_FCLK: assert property (@(posedge clk) disable iff (!rst_n)
    (load && pwr_on) |=> fclk_out); // R6
  AST_FREEZE_NO_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((link_mode == MODE_RUN) && !bit_en && !cap && pwr_on)
      |=> ($stable(lane_out) && $stable(fclk_out))); // R11
endmodule

bind pixel_lane_serializer pixel_lane_serializer_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bit_en   (bit_en),
  .pwr_on   (pwr_on),
  .cap      (cap_stb),
  .load     (load_stb),
  .lane_out (lane_out),
  .fclk_out (fclk_out),
  .link_mode(link_mode)
);

// File: tb/pixel_lane_serializer_bench.sv
`timescale 1ns/1ps
module pixel_lane_serializer_bench;
  logic        clk = 1'b0;
  logic        rst_n, bit_en, pwr_on, pclk_in, cap_fall, bus_swap;
  logic [26:0] pix_in;
  logic [1:0]  lane_sel;
  logic [2:0]  lane_out;
  logic        fclk_out;
  logic [1:0]  link_mode;

  int n_chk = 0, n_fail = 0;
  int nl = 1, per = 30;
  int pend = 0, slot = 0, slot_err = 0, quiet_err = 0;
  bit coll = 0;
  logic [29:0] cur;
  logic [29:0] expq [0:7];
  int qh = 0, qt = 0;
  string tag_now = "";

  always #2 clk = ~clk;

  pixel_lane_serializer u_pixel_lane_serializer (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .pwr_on(pwr_on), .pclk_in(pclk_in),
    .pix_in(pix_in), .cap_fall(cap_fall), .bus_swap(bus_swap), .lane_sel(lane_sel),
    .lane_out(lane_out), .fclk_out(fclk_out), .link_mode(link_mode)
  );

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(4 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R1..: actual=timeout expected=completion");
    report();
    $finish;
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [29:0] exp_word(input logic [26:0] d, input logic sw);
    logic [23:0] c;
    logic [26:0] p;
    for (int i = 0; i < 24; i++) c[i] = sw ? d[23-i] : d[i];
    p = {d[26:24], c};
    return {2'b00, ~(^p), p};
  endfunction

  task automatic set_lanes(input logic [1:0] sel);
    lane_sel = sel;
    nl  = (sel == 2'd0) ? 1 : int'(sel);
    per = 30 / nl;
  endtask

  task automatic finish_word();
    check((cur == expq[qh % 8]) && (slot_err == 0), {tag_now, " word"},
          {34'd0, cur} | (64'(slot_err) << 40), {34'd0, expq[qh % 8]});
    qh++;
    coll = 0;
    slot_err = 0;
  endtask

  task automatic sample();
    if (pend > 0) begin
      pend--;
      if (pend == 0) begin
        if (coll) finish_word();
        coll = 1;
        slot = 0;
        cur  = '0;
      end
    end
    if (coll && (slot < per)) begin
      for (int k = 0; k < 3; k++) begin
        if (k < nl) cur[slot*nl+k] = lane_out[k];
        else if (lane_out[k]) slot_err++;
      end
      if (fclk_out !== (slot < per / 2)) slot_err++;
      slot++;
    end else if ((lane_out != 3'b000) || fclk_out) begin
      quiet_err++;
    end
  endtask

  task automatic pixel(input logic [26:0] dr, input logic [26:0] df, input bit expect_word);
    int hi;
    hi = (per + 1) / 2;
    pclk_in = 1'b1;
    pix_in  = dr;
    if (expect_word && !cap_fall) begin
      pend = 2;
      expq[qt % 8] = exp_word(dr, bus_swap);
      qt++;
    end
    for (int c = 1; c <= per; c++) begin
      @(negedge clk);
      sample();
      if (c == hi) begin
        pclk_in = 1'b0;
        pix_in  = df;
        if (expect_word && cap_fall) begin
          pend = 2;
          expq[qt % 8] = exp_word(df, bus_swap);
          qt++;
        end
      end
    end
  endtask

  task automatic tail();
    for (int c = 0; c < per + 3; c++) begin
      @(negedge clk);
      sample();
    end
    if (coll) finish_word();
    check(quiet_err == 0, {tag_now, " quiet gaps"}, 64'(quiet_err), 64'd0);
    quiet_err = 0;
  endtask

  task automatic t_reset();
    tag_now = "R10 reset";
    check(link_mode == 2'd1, "R10 reset mode", 64'(link_mode), 64'd1);
    check(lane_out == 3'b000 && !fclk_out, "R10 reset outputs", {60'd0, fclk_out, lane_out}, 64'd0);
  endtask

  task automatic t_one_lane();
    tag_now = "R1 R2 R6 R8 one lane";
    set_lanes(2'd1);
    pixel(27'h1234567, 27'h1234567, 0);
    check(link_mode == 2'd1, "R8 still standby after one edge", 64'(link_mode), 64'd1);
    pixel(27'h7654321, 27'h7654321, 0);
    check(link_mode == 2'd2, "R8 active after two edges", 64'(link_mode), 64'd2);
    pixel(27'h0000000, 27'h0, 1);
    pixel(27'h0000001, 27'h0, 1);
    pixel(27'h7FFFFFF, 27'h0, 1);
    pixel(27'h5A3C1E7, 27'h0, 1);
    pixel(27'h4000000, 27'h0, 1);
    tail();
  endtask

  task automatic t_swap();
    tag_now = "R3 swap";
    bus_swap = 1'b1;
    pixel(27'h0000001, 27'h0, 1);
    pixel(27'h0800000, 27'h0, 1);
    pixel(27'h4ABCDEF, 27'h0, 1);
    pixel(27'h30F00A5, 27'h0, 1);
    tail();
    bus_swap = 1'b0;
  endtask

  task automatic t_two_lane();
    tag_now = "R4 two lanes";
    set_lanes(2'd2);
    pixel(27'h2468ACE, 27'h0, 1);
    pixel(27'h7FFFFFF, 27'h0, 1);
    pixel(27'h0000003, 27'h0, 1);
    tail();
  endtask

  task automatic t_three_lane();
    tag_now = "R4 R6 three lanes";
    set_lanes(2'd3);
    pixel(27'h13579BD, 27'h0, 1);
    pixel(27'h6DB6DB6, 27'h0, 1);
    pixel(27'h0000000, 27'h0, 1);
    tail();
  endtask

  task automatic t_fall_edge();
    tag_now = "R5 falling capture";
    cap_fall = 1'b1;
    pixel(27'h1111111, 27'h2222222, 1);
    pixel(27'h7000000, 27'h00000FF, 1);
    pixel(27'h0ABCDEF, 27'h5432100, 1);
    tail();
    cap_fall = 1'b0;
  endtask

  task automatic t_stop();
    logic [2:0] l1;
    logic       f1;
    tag_now = "R7 R11 stop";
    pclk_in = 1'b1;
    pix_in  = 27'h3C3C3C3;
    repeat (8) @(negedge clk);
    pclk_in = 1'b0;
    bit_en  = 1'b0;
    @(negedge clk);
    l1 = lane_out;
    f1 = fclk_out;
    repeat (98) @(negedge clk);
    check(lane_out == l1 && fclk_out == f1, "R11 frozen without enable",
          {60'd0, fclk_out, lane_out}, {60'd0, f1, l1});
    check(link_mode == 2'd2, "R11 no idle count without enable", 64'(link_mode), 64'd2);
    @(negedge clk);
    bit_en = 1'b1;
    repeat (63) @(negedge clk);
    check(link_mode == 2'd2, "R7 active after 63 idle enables", 64'(link_mode), 64'd2);
    @(negedge clk);
    check(link_mode == 2'd1, "R7 standby after 64 idle enables", 64'(link_mode), 64'd1);
    check(lane_out == 3'b000 && !fclk_out, "R7 quiet in standby", {60'd0, fclk_out, lane_out}, 64'd0);
  endtask

  task automatic t_wake();
    tag_now = "R8 R4 wake lane_sel 0";
    set_lanes(2'd0);
    pixel(27'h0F0F0F0, 27'h0, 0);
    check(link_mode == 2'd1, "R8 one edge keeps standby", 64'(link_mode), 64'd1);
    pixel(27'h1E1E1E1, 27'h0, 0);
    check(link_mode == 2'd2, "R8 second edge wakes", 64'(link_mode), 64'd2);
    pixel(27'h2D2D2D2, 27'h0, 1);
    pixel(27'h0000007, 27'h0, 1);
    tail();
  endtask

  task automatic t_shutdown();
    tag_now = "R9 shutdown";
    pwr_on = 1'b0;
    @(negedge clk);
    check(link_mode == 2'd0, "R9 shutdown entered", 64'(link_mode), 64'd0);
    check(lane_out == 3'b000 && !fclk_out, "R9 quiet in shutdown", {60'd0, fclk_out, lane_out}, 64'd0);
    pixel(27'h1111111, 27'h0, 0);
    pixel(27'h2222222, 27'h0, 0);
    check(link_mode == 2'd0, "R9 edges ignored in shutdown", 64'(link_mode), 64'd0);
    pwr_on = 1'b1;
    @(negedge clk);
    check(link_mode == 2'd1, "R9 standby after power on", 64'(link_mode), 64'd1);
    pixel(27'h3333333, 27'h0, 0);
    check(link_mode == 2'd1, "R9 one edge after power on", 64'(link_mode), 64'd1);
    pixel(27'h4444444, 27'h0, 0);
    check(link_mode == 2'd2, "R9 R8 active after two edges", 64'(link_mode), 64'd2);
    check(quiet_err == 0, "R9 quiet before first word", 64'(quiet_err), 64'd0);
  endtask

  initial begin
    rst_n    = 1'b0;
    bit_en   = 1'b1;
    pwr_on   = 1'b1;
    pclk_in  = 1'b0;
    pix_in   = '0;
    cap_fall = 1'b0;
    bus_swap = 1'b0;
    lane_sel = 2'd1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_one_lane();
    t_swap();
    t_two_lane();
    t_three_lane();
    t_fall_edge();
    t_stop();
    t_wake();
    t_shutdown();
    report();
    $finish;
  end
endmodule